// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the register side of a multi-channel DMA controller. Software reaches it through a 32-bit, word-only bus port with a simple request/acknowledge handshake. For each channel it holds a control/status word, a control-block pointer and a debug word. It also keeps read-only copies of the fields of the control block that the channel is working on. The transfer engine loads those copies through a side port. A global 16-bit channel enable mask and an interrupt summary word sit at fixed offsets above the channel area.

The status word mixes several kinds of bit. Some bits are plain read/write under a fixed mask. The end and interrupt flags are write-1-to-clear. The reset bit clears the channel and is never stored, and the abort bit is never stored either. When a status write takes the active bit from 0 to 1, the block sends that channel a one-cycle start pulse to the engine. When the engine reports that a control block is finished, the block sets the end flag, clears active and sets paused. If the engine reports that interrupts are enabled, it also raises the interrupt flag, the summary bit and the channel's interrupt line.

The bus handshake is a two-state machine. In BUS_IDLE a pending request is accepted and carried out, and the machine moves to BUS_ACK. In BUS_ACK the acknowledge is high for exactly one cycle, read data is valid, and the machine always returns to BUS_IDLE.

Top module: `dma_ctrl_regs`

## Requirements
- R1: A request seen in the idle state is carried out on that clock edge. The acknowledge is then high for exactly one cycle, with read data valid in the same cycle. A write returns read data 0.
- R2: A write to the status word (channel offset 0x00) replaces only the bits under mask 0x30FF0001 with the written value. Every other bit keeps its value.
- R3: Writing 1 to status bit 1 (end) or bit 2 (interrupt) clears that flag. Clearing the interrupt flag also clears the channel's bit in the interrupt summary and drops its interrupt line.
- R4: Writing 1 to status bit 31 clears the status word and the control-block pointer (offset 0x04). It leaves the interrupt summary and the line untouched. Neither bit 31 nor bit 30 (abort) is stored, and bit 30 has no other effect.
- R5: A status write whose result has bit 0 (active) set, while bit 0 was 0 before, gives a one-cycle pulse on that channel's start output, and on no other channel. The pulse coincides with the acknowledge.
- R6: An engine completion for a channel sets end (bit 1) and paused (bit 4) and clears active. With the interrupt-enable input high it also sets bit 2, the summary bit and the interrupt line, all visible one cycle later.
- R7: The engine field load writes the read-only copies, with the select values 0 info (0x08), 1 source (0x0C), 2 destination (0x10), 3 length (0x14), 4 stride (0x18), 5 next pointer (0x1C) and 6 control-block pointer (0x04). Bus writes to 0x08 through 0x1C are ignored. Offset 0x20 is a read/write debug word.
- R8: For addresses below 0xF00, address bits [11:8] select the channel and bits [7:0] select the register. Channels are independent.
- R9: Offset 0xFF0 holds the 16-bit enable mask, which drives the per-channel enable outputs. Offset 0xFE0 reads the interrupt summary, and writes to it are ignored. After reset the mask is 0xFFFF and the summary is 0.
- R10: Reads from undefined offsets return 0, and writes to them change nothing.
- R11: The engine pointer output shows the control-block pointer of the channel named on the engine channel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus request, held until acknowledged |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| bus_rdata_o | output | 32 | Read data, valid with the acknowledge |
| eng_ld_i | input | 1 | Engine field load strobe |
| eng_done_i | input | 1 | Engine control-block completion strobe |
| eng_ch_i | input | 4 | Channel addressed by the engine |
| eng_sel_i | input | 3 | Field select for the load |
| eng_data_i | input | 32 | Field value for the load |
| eng_irq_en_i | input | 1 | Completion raises an interrupt |
| eng_ptr_o | output | 32 | Control-block pointer of the engine's channel |
| start_o | output | NUM_CH | Per-channel start pulse |
| chan_en_o | output | NUM_CH | Per-channel enable from the mask |
| irq_o | output | NUM_CH | Per-channel interrupt line |

## Verification
A status bit merged wrongly appears on the very next readback of the status word. A broken 0-to-1 detection shows up as a missing or extra start pulse, in the same cycle as the acknowledge of the status write. A summary bit that has lost track of its flag is visible on the interrupt line one cycle after the completion or the clearing write. A decode slip is seen when the write to one channel, or to the global words, shows up in a read of a neighbouring register.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned ENA_W   = 16;
    localparam int unsigned MAX_CH  = 15;

    // channel register offsets
    localparam logic [7:0] OFS_STAT = 8'h00;
    localparam logic [7:0] OFS_PTR  = 8'h04;
    localparam logic [7:0] OFS_INFO = 8'h08;
    localparam logic [7:0] OFS_SRC  = 8'h0C;
    localparam logic [7:0] OFS_DST  = 8'h10;
    localparam logic [7:0] OFS_LEN  = 8'h14;
    localparam logic [7:0] OFS_STRD = 8'h18;
    localparam logic [7:0] OFS_NEXT = 8'h1C;
    localparam logic [7:0] OFS_DBG  = 8'h20;

    // global words
    localparam logic [ADDR_W-1:0] CHAN_LIMIT = 12'hF00;
    localparam logic [ADDR_W-1:0] GLB_IRQ    = 12'hFE0;
    localparam logic [ADDR_W-1:0] GLB_ENA    = 12'hFF0;

    // status bit positions
    localparam int unsigned SB_ACTIVE = 0;
    localparam int unsigned SB_END    = 1;
    localparam int unsigned SB_INT    = 2;
    localparam int unsigned SB_PAUSED = 4;
    localparam int unsigned SB_ABORT  = 30;
    localparam int unsigned SB_RESET  = 31;

    localparam logic [WORD_W-1:0] STAT_RW_MASK = 32'h30FF_0001;

    typedef enum logic [2:0] {
        FLD_INFO   = 3'd0,
        FLD_SRC    = 3'd1,
        FLD_DST    = 3'd2,
        FLD_LEN    = 3'd3,
        FLD_STRIDE = 3'd4,
        FLD_NEXT   = 3'd5,
        FLD_PTR    = 3'd6,
        FLD_NONE   = 3'd7
    } fld_e;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_st_e;

    typedef struct packed {
        logic             chan_area;
        logic [3:0]       ch;
        logic [7:0]       ofs;
        logic             glb_irq;
        logic             glb_ena;
    } dec_t;

endpackage

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ack_o,
    output logic              accept_o,
    output dec_t              dec_o
);

    bus_st_e state_q;
    bus_st_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_i) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ack_o    = 1'b0;
        accept_o = 1'b0;
        unique case (state_q)
            BUS_IDLE: accept_o = req_i;
            BUS_ACK:  ack_o    = 1'b1;
            default:  ack_o    = 1'b0;
        endcase
    end

    // address decode
    always_comb begin
        dec_o.chan_area = (addr_i < CHAN_LIMIT);
        dec_o.ch        = addr_i[11:8];
        dec_o.ofs       = addr_i[7:0];
        dec_o.glb_irq   = (addr_i == GLB_IRQ);
        dec_o.glb_ena   = (addr_i == GLB_ENA);
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_ofs_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic              eng_ld_i,
    input  fld_e              eng_sel_i,
    input  logic [WORD_W-1:0] eng_data_i,
    input  logic              eng_done_i,
    input  logic              eng_irq_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [WORD_W-1:0] ptr_o,
    output logic              start_o,
    output logic              int_set_o,
    output logic              int_clr_o
);

    logic [WORD_W-1:0] stat_q, stat_d;
    logic [WORD_W-1:0] ptr_q, ptr_d;
    logic [WORD_W-1:0] info_q, src_q, dst_q, len_q, strd_q, next_q, dbg_q;
    logic              start_q, start_d;
    logic              stat_wr;

    assign stat_wr = bus_wr_i && (bus_ofs_i == OFS_STAT);

    // status word: engine completion first, bus write merged on top
    always_comb begin
        stat_d = stat_q;
        if (eng_done_i) begin
            stat_d[SB_ACTIVE] = 1'b0;
            stat_d[SB_END]    = 1'b1;
            stat_d[SB_PAUSED] = 1'b1;
            if (eng_irq_en_i) stat_d[SB_INT] = 1'b1;
        end
        if (stat_wr) begin
            if (bus_wdata_i[SB_RESET]) stat_d = '0;
            if (bus_wdata_i[SB_END])   stat_d[SB_END] = 1'b0;
            if (bus_wdata_i[SB_INT])   stat_d[SB_INT] = 1'b0;
            stat_d = (stat_d & ~STAT_RW_MASK) | (bus_wdata_i & STAT_RW_MASK);
        end
        start_d = stat_wr && !stat_q[SB_ACTIVE] && stat_d[SB_ACTIVE];
    end

    always_comb begin
        ptr_d = ptr_q;
        if (eng_ld_i && (eng_sel_i == FLD_PTR)) ptr_d = eng_data_i;
        if (bus_wr_i && (bus_ofs_i == OFS_PTR)) ptr_d = bus_wdata_i;
        if (stat_wr && bus_wdata_i[SB_RESET])   ptr_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= '0;
            ptr_q   <= '0;
            start_q <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            ptr_q   <= ptr_d;
            start_q <= start_d;
        end
    end

    // mirrored control-block fields, loaded only by the engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            strd_q <= '0;
            next_q <= '0;
        end else if (eng_ld_i) begin
            case (eng_sel_i)
                FLD_INFO:   info_q <= eng_data_i;
                FLD_SRC:    src_q  <= eng_data_i;
                FLD_DST:    dst_q  <= eng_data_i;
                FLD_LEN:    len_q  <= eng_data_i;
                FLD_STRIDE: strd_q <= eng_data_i;
                FLD_NEXT:   next_q <= eng_data_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_q <= '0;
        end else if (bus_wr_i && (bus_ofs_i == OFS_DBG)) begin
            dbg_q <= bus_wdata_i;
        end
    end

    always_comb begin
        case (bus_ofs_i)
            OFS_STAT: rd_data_o = stat_q;
            OFS_PTR:  rd_data_o = ptr_q;
            OFS_INFO: rd_data_o = info_q;
            OFS_SRC:  rd_data_o = src_q;
            OFS_DST:  rd_data_o = dst_q;
            OFS_LEN:  rd_data_o = len_q;
            OFS_STRD: rd_data_o = strd_q;
            OFS_NEXT: rd_data_o = next_q;
            OFS_DBG:  rd_data_o = dbg_q;
            default:  rd_data_o = '0;
        endcase
    end

    assign ptr_o     = ptr_q;
    assign start_o   = start_q;
    assign int_set_o = eng_done_i && eng_irq_en_i;
    assign int_clr_o = stat_wr && bus_wdata_i[SB_INT];

endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
    import dma_regs_pkg::*;
#(
    parameter int unsigned NUM_CH = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ena_wr_i,
    input  logic [ENA_W-1:0]  ena_wdata_i,
    input  logic [NUM_CH-1:0] int_set_i,
    input  logic [NUM_CH-1:0] int_clr_i,
    output logic [ENA_W-1:0]  ena_o,
    output logic [NUM_CH-1:0] irq_sum_o
);

    logic [ENA_W-1:0]  ena_q;
    logic [NUM_CH-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '1;
        end else if (ena_wr_i) begin
            ena_q <= ena_wdata_i;
        end
    end

    // a completion in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= (sum_q & ~int_clr_i) | int_set_i;
        end
    end

    assign ena_o     = ena_q;
    assign irq_sum_o = sum_q;

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_regs_pkg::*;
#(
    parameter int unsigned NUM_CH = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [11:0]       bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              bus_ack_o,
    output logic [31:0]       bus_rdata_o,
    input  logic              eng_ld_i,
    input  logic              eng_done_i,
    input  logic [3:0]        eng_ch_i,
    input  logic [2:0]        eng_sel_i,
    input  logic [31:0]       eng_data_i,
    input  logic              eng_irq_en_i,
    output logic [31:0]       eng_ptr_o,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] chan_en_o,
    output logic [NUM_CH-1:0] irq_o
);

    localparam int unsigned CH_W = 4;

    logic              accept;
    dec_t              dec;
    logic              wr_acc;
    logic [WORD_W-1:0] ch_rd  [NUM_CH];
    logic [WORD_W-1:0] ch_ptr [NUM_CH];
    logic [NUM_CH-1:0] int_set, int_clr;
    logic [ENA_W-1:0]  ena;
    logic [NUM_CH-1:0] irq_sum;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    dma_bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (bus_req_i),
        .addr_i   (bus_addr_i),
        .ack_o    (bus_ack_o),
        .accept_o (accept),
        .dec_o    (dec)
    );

    assign wr_acc = accept && bus_we_i;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ch_bus_wr;
        logic ch_eng_ld;
        logic ch_eng_done;
        assign ch_bus_wr   = wr_acc && dec.chan_area && (dec.ch == CH_W'(i));
        assign ch_eng_ld   = eng_ld_i && (eng_ch_i == CH_W'(i));
        assign ch_eng_done = eng_done_i && (eng_ch_i == CH_W'(i));

        dma_chan_regs u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .bus_wr_i     (ch_bus_wr),
            .bus_ofs_i    (dec.ofs),
            .bus_wdata_i  (bus_wdata_i),
            .eng_ld_i     (ch_eng_ld),
            .eng_sel_i    (fld_e'(eng_sel_i)),
            .eng_data_i   (eng_data_i),
            .eng_done_i   (ch_eng_done),
            .eng_irq_en_i (eng_irq_en_i),
            .rd_data_o    (ch_rd[i]),
            .ptr_o        (ch_ptr[i]),
            .start_o      (start_o[i]),
            .int_set_o    (int_set[i]),
            .int_clr_o    (int_clr[i])
        );
    end

    dma_glob_regs #(.NUM_CH(NUM_CH)) u_glob (
        .clk         (clk),
        .rst_n       (rst_n),
        .ena_wr_i    (wr_acc && dec.glb_ena),
        .ena_wdata_i (bus_wdata_i[ENA_W-1:0]),
        .int_set_i   (int_set),
        .int_clr_i   (int_clr),
        .ena_o       (ena),
        .irq_sum_o   (irq_sum)
    );

    // read selection
    always_comb begin
        rd_mux = '0;
        if (dec.chan_area) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (dec.ch == CH_W'(i)) rd_mux = ch_rd[i];
            end
        end else if (dec.glb_irq) begin
            rd_mux = WORD_W'(irq_sum);
        end else if (dec.glb_ena) begin
            rd_mux = WORD_W'(ena);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= bus_we_i ? '0 : rd_mux;
        end
    end

    always_comb begin
        eng_ptr_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (eng_ch_i == CH_W'(i)) eng_ptr_o = ch_ptr[i];
        end
    end

    assign bus_rdata_o = rdata_q;
    assign chan_en_o   = ena[NUM_CH-1:0];
    assign irq_o       = irq_sum;

endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
    parameter int unsigned NUM_CH = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_i,
    input logic              bus_we_i,
    input logic              bus_ack_o,
    input logic              eng_done_i,
    input logic              eng_irq_en_i,
    input logic [NUM_CH-1:0] start_o,
    input logic [NUM_CH-1:0] chan_en_o,
    input logic [NUM_CH-1:0] irq_o
);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |=> !bus_ack_o); // R1

    AST_START_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |-> bus_ack_o); // R5

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o)); // R5

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |-> $past(bus_req_i && bus_we_i)); // R5

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~$past(irq_o)) != '0) |-> $past(eng_done_i && eng_irq_en_i)); // R6

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_o & $past(irq_o)) != '0) |-> $past(bus_req_i && bus_we_i && !bus_ack_o)); // R3

    AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_req_i && bus_we_i) |-> $stable(chan_en_o)); // R9

endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_ack_o    (bus_ack_o),
    .eng_done_i   (eng_done_i),
    .eng_irq_en_i (eng_irq_en_i),
    .start_o      (start_o),
    .chan_en_o    (chan_en_o),
    .irq_o        (irq_o)
);

// File: tb/dma_ctrl_regs_tb.sv
module dma_ctrl_regs_tb_top;

    localparam int NCH = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [11:0] bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic        bus_ack_o;
    logic [31:0] bus_rdata_o;
    logic        eng_ld_i = 1'b0;
    logic        eng_done_i = 1'b0;
    logic [3:0]  eng_ch_i = '0;
    logic [2:0]  eng_sel_i = '0;
    logic [31:0] eng_data_i = '0;
    logic        eng_irq_en_i = 1'b0;
    logic [31:0] eng_ptr_o;
    logic [NCH-1:0] start_o, chan_en_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_ctrl_regs #(.NUM_CH(NCH)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [11:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic [NCH-1:0] st);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
        do @(negedge clk); while (!bus_ack_o);
        rd = bus_rdata_o;
        st = start_o;
        bus_req_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] wd, output logic [NCH-1:0] st);
        logic [31:0] rd;
        xfer(1'b1, addr, wd, rd, st);
    endtask

    task automatic rd(input logic [11:0] addr, output logic [31:0] d);
        logic [NCH-1:0] st;
        xfer(1'b0, addr, '0, d, st);
    endtask

    function automatic logic [11:0] ca(input int ch, input logic [7:0] ofs);
        return {ch[3:0], ofs};
    endfunction

    task automatic eng_load(input int ch, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        eng_ld_i = 1'b1; eng_ch_i = ch[3:0]; eng_sel_i = sel; eng_data_i = d;
        @(negedge clk);
        eng_ld_i = 1'b0;
    endtask

    task automatic eng_fin(input int ch, input logic ien);
        @(negedge clk);
        eng_done_i = 1'b1; eng_ch_i = ch[3:0]; eng_irq_en_i = ien;
        @(negedge clk);
        eng_done_i = 1'b0; eng_irq_en_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R9 enable outputs after reset", 32'(chan_en_o), 32'h7FFF);
        chk("R9 irq lines after reset", 32'(irq_o), 0);
        chk("R5 no start after reset", 32'(start_o), 0);
        rd(ca(0, 8'h00), d); chk("R9 status reset value", d, 0);
        rd(ca(0, 8'h04), d); chk("R9 pointer reset value", d, 0);
        rd(12'hFF0, d);      chk("R9 enable mask reset", d, 32'hFFFF);
        rd(12'hFE0, d);      chk("R9 summary reset", d, 0);
        @(negedge clk);      chk("R1 ack lasts one cycle", 32'(bus_ack_o), 0);
    endtask

    task automatic t_mask_and_start();
        logic [31:0] d; logic [NCH-1:0] st;
        wr(ca(1, 8'h00), 32'hFFFF_FFFE, st);
        chk("R5 no start while active stays 0", 32'(st), 0);
        rd(ca(1, 8'h00), d); chk("R2 masked status write", d, 32'h30FF_0000);
        wr(ca(1, 8'h00), 32'h0000_0001, st);
        chk("R5 start pulse on 0->1", 32'(st), 32'h2);
        @(negedge clk); chk("R5 start lasts one cycle", 32'(start_o), 0);
        rd(ca(1, 8'h00), d); chk("R2 status after second write", d, 32'h1);
        wr(ca(1, 8'h00), 32'h0000_0001, st);
        chk("R5 no start when already active", 32'(st), 0);
        wr(ca(1, 8'h00), 32'h0, st);
        wr(ca(1, 8'h00), 32'h1, st);
        chk("R5 restart after clear", 32'(st), 32'h2);
    endtask

    task automatic t_done_and_clear();
        logic [31:0] d; logic [NCH-1:0] st;
        eng_fin(1, 1'b1);
        chk("R6 irq line raised", 32'(irq_o), 32'h2);
        rd(ca(1, 8'h00), d); chk("R6 status after completion", d, 32'h16);
        rd(12'hFE0, d);      chk("R6 summary bit set", d, 32'h2);
        wr(ca(1, 8'h00), 32'h2, st);
        rd(ca(1, 8'h00), d); chk("R3 end flag cleared", d, 32'h14);
        chk("R3 irq kept after end clear", 32'(irq_o), 32'h2);
        wr(ca(1, 8'h00), 32'h4, st);
        rd(ca(1, 8'h00), d); chk("R3 int flag cleared", d, 32'h10);
        chk("R3 irq line dropped", 32'(irq_o), 0);
        rd(12'hFE0, d);      chk("R3 summary cleared", d, 0);
        wr(ca(5, 8'h00), 32'h1, st);
        eng_fin(5, 1'b0);
        rd(ca(5, 8'h00), d); chk("R6 completion without interrupt", d, 32'h12);
        chk("R6 no irq without enable", 32'(irq_o), 0);
    endtask

    task automatic t_reset_abort();
        logic [31:0] d; logic [NCH-1:0] st;
        wr(ca(2, 8'h04), 32'h1000, st);
        wr(ca(2, 8'h00), 32'h00FF_0001, st);
        chk("R5 start on channel 2 only", 32'(st), 32'h4);
        wr(ca(2, 8'h00), 32'h8000_0000, st);
        rd(ca(2, 8'h00), d); chk("R4 reset clears status", d, 0);
        rd(ca(2, 8'h04), d); chk("R4 reset clears pointer", d, 0);
        wr(ca(2, 8'h00), 32'h4000_0000, st);
        chk("R4 abort gives no start", 32'(st), 0);
        rd(ca(2, 8'h00), d); chk("R4 abort not stored", d, 0);
        wr(ca(3, 8'h00), 32'h1, st);
        eng_fin(3, 1'b1);
        wr(ca(3, 8'h00), 32'h8000_0000, st);
        rd(ca(3, 8'h00), d); chk("R4 reset clears int flag", d, 0);
        chk("R4 summary untouched by reset", 32'(irq_o), 32'h8);
        wr(ca(3, 8'h00), 32'h4, st);
        chk("R3 clear after reset drops line", 32'(irq_o), 0);
    endtask

    task automatic t_mirror();
        logic [31:0] d; logic [NCH-1:0] st;
        for (int f = 0; f < 6; f++) eng_load(4, 3'(f), 32'hA000_0000 + 32'(f));
        for (int f = 0; f < 6; f++) begin
            rd(ca(4, 8'(8 + 4 * f)), d);
            chk("R7 mirror field readback", d, 32'hA000_0000 + 32'(f));
        end
        wr(ca(4, 8'h08), 32'hDEAD, st);
        rd(ca(4, 8'h08), d); chk("R7 mirror ignores bus write", d, 32'hA000_0000);
        wr(ca(4, 8'h20), 32'h5A5A_1234, st);
        rd(ca(4, 8'h20), d); chk("R7 debug read/write", d, 32'h5A5A_1234);
        eng_load(4, 3'd6, 32'h2000);
        rd(ca(4, 8'h04), d); chk("R7 engine pointer load", d, 32'h2000);
        chk("R11 engine pointer output", eng_ptr_o, 32'h2000);
    endtask

    task automatic t_global();
        logic [31:0] d; logic [NCH-1:0] st;
        wr(12'hFF0, 32'h0001_2345, st);
        rd(12'hFF0, d); chk("R9 enable keeps 16 bits", d, 32'h2345);
        chk("R9 enable outputs", 32'(chan_en_o), 32'h2345);
        wr(12'hFE0, 32'hFFFF, st);
        rd(12'hFE0, d); chk("R9 summary write ignored", d, 0);
        chk("R9 summary write leaves lines", 32'(irq_o), 0);
        wr(ca(4, 8'h24), 32'h1234, st);
        rd(ca(4, 8'h24), d); chk("R10 undefined offset reads 0", d, 0);
        rd(ca(4, 8'h20), d); chk("R10 undefined write harmless", d, 32'h5A5A_1234);
        rd(12'hF00, d);      chk("R10 undefined global reads 0", d, 0);
        wr(12'hFF0, 32'hFFFF, st);
        wr(ca(0, 8'h04), 32'h111, st);
        wr(ca(14, 8'h04), 32'hEEE, st);
        rd(ca(0, 8'h04), d);  chk("R8 channel 0 pointer", d, 32'h111);
        rd(ca(14, 8'h04), d); chk("R8 channel 14 pointer", d, 32'hEEE);
        @(negedge clk); eng_ch_i = 4'd14;
        @(negedge clk); chk("R11 pointer follows engine channel", eng_ptr_o, 32'hEEE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_and_start();
        t_done_and_clear();
        t_reset_abort();
        t_mirror();
        t_global();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule